// File: doc/BRIEF.md
# Address Table Command Engine

This block manages a small forwarding table for a switch. Each table slot holds a MAC address, a VLAN ID, an age value, a port bitmap and a two-bit entry status. The table lives in flip-flops. Software loads an entry image into three 32-bit write words. It then writes a command code with the start bit set. The engine raises busy and walks the table one slot per clock. When it finishes it drops busy and reports its result through three flags in the status image and through three 32-bit read words.

The engine supports five operations. A lookup returns the entry whose MAC and VID match the key. A store either overwrites the matching entry, fills the lowest empty slot, or erases the matching entry when the written status is empty. A flush empties every slot. Search-start and search-next walk the table in ascending slot order and return one valid entry per command. Software dumps the table by issuing search-start, then search-next, until the end flag appears.

Top module: `atbl_engine`

## Requirements
- R1: After reset the status image reads zero (not busy, no flags, code 0), all three read words are zero and every slot is empty.
- R2: A command starts only when `cmd_wr` is high, `cmd_start` is 1 and busy is clear. Busy (status bit 15) then reads 1 from the next clock until the command completes. A write with `cmd_start` = 0, or any write while busy, has no effect. Status bits [2:0] show the code of the last accepted command.
- R3: Entry word layout. Word 0 holds MAC bytes 0..3 at [31:24], [23:16], [15:8], [7:0]. Word 1 holds MAC byte 4 at [31:24], byte 5 at [23:16] and the VID at [11:0]. Word 2 holds the age at [31:24], the port bitmap at [11:4] and the status at [1:0] (0 empty, 1 dynamic, 3 static). A lookup (code 0) that finds an entry returns exactly the stored words in the read words, with all unused bits zero.
- R4: A lookup whose MAC and VID match no valid slot completes with the invalid flag (status bit 12) set. Every command clears hit, end and invalid when it starts.
- R5: A store (code 1) whose MAC and VID match a valid slot overwrites that slot in place. The same MAC with a different VID is a separate entry.
- R6: A store whose status field is empty erases the slot that matches its MAC and VID. Other entries are left untouched.
- R7: A store that matches no entry takes the lowest-numbered empty slot. When no slot is empty, it sets the invalid flag and leaves the table unchanged.
- R8: A flush (code 2) empties every slot. It holds busy for at least DEPTH cycles.
- R9: Search-start (code 4) scans from slot 0. Search-next (code 5) resumes at the slot after the last reported one. Each search stops at the first valid slot, sets hit (status bit 13) and places that entry in the read words, so entries come out in ascending slot order.
- R10: The end flag (status bit 14) is set when a search examines the last slot. It is set together with hit when that slot is valid, and alone when no valid slot remained. A search-next after the end reports end without hit.
- R11: Command codes 3, 6 and 7 never raise busy and leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_start | input | 1 | Busy/start bit value being written |
| cmd_op | input | 3 | Command code |
| wr_word0 | input | 32 | Entry write word 0 (MAC bytes 0..3) |
| wr_word1 | input | 32 | Entry write word 1 (MAC bytes 4..5, VID) |
| wr_word2 | input | 32 | Entry write word 2 (age, port bitmap, status) |
| cmd_status | output | 16 | Status image: busy[15], end[14], hit[13], invalid[12], code[2:0] |
| rd_word0 | output | 32 | Result word 0 |
| rd_word1 | output | 32 | Result word 1 |
| rd_word2 | output | 32 | Result word 2 |

## Verification
The bench builds the engine with DEPTH = 8. At that size a table-full store takes only eight prior stores, and a full dump fits in a few commands, so the case where hit and end appear together on the last slot is reached directly. Reuse of a freed slot is observed through search order. Slot indices and the index one past the end also stay narrow enough that the scan wrap conditions are exercised by every search that runs off the table.

// File: rtl/atbl_pkg.sv
package atbl_pkg;

    localparam int MAC_W  = 48;
    localparam int VID_W  = 12;
    localparam int AGE_W  = 8;
    localparam int PMAP_W = 8;
    localparam int OP_W   = 3;

    localparam logic [OP_W-1:0] OP_LOOKUP = 3'd0;
    localparam logic [OP_W-1:0] OP_STORE  = 3'd1;
    localparam logic [OP_W-1:0] OP_FLUSH  = 3'd2;
    localparam logic [OP_W-1:0] OP_SSTART = 3'd4;
    localparam logic [OP_W-1:0] OP_SNEXT  = 3'd5;

    typedef enum logic [1:0] {
        ENT_EMPTY  = 2'd0,
        ENT_DYN    = 2'd1,
        ENT_RSVD   = 2'd2,
        ENT_STATIC = 2'd3
    } ent_st_e;

    typedef struct packed {
        logic [MAC_W-1:0]  mac;
        logic [VID_W-1:0]  vid;
        logic [AGE_W-1:0]  age;
        logic [PMAP_W-1:0] pmap;
        ent_st_e           st;
    } entry_t;

    function automatic entry_t words_to_entry(logic [31:0] w0, logic [31:0] w1,
                                              logic [31:0] w2);
        entry_t e;
        e.mac  = {w0, w1[31:16]};
        e.vid  = w1[VID_W-1:0];
        e.age  = w2[31:24];
        e.pmap = w2[4 +: PMAP_W];
        e.st   = ent_st_e'(w2[1:0]);
        return e;
    endfunction

    function automatic logic [31:0] entry_word0(entry_t e);
        return e.mac[MAC_W-1:16];
    endfunction

    function automatic logic [31:0] entry_word1(entry_t e);
        return {e.mac[15:0], 4'h0, e.vid};
    endfunction

    function automatic logic [31:0] entry_word2(entry_t e);
        return {e.age, 12'h000, e.pmap, 2'b00, e.st};
    endfunction

    function automatic logic op_known(logic [OP_W-1:0] op);
        return (op == OP_LOOKUP) || (op == OP_STORE) || (op == OP_FLUSH) ||
               (op == OP_SSTART) || (op == OP_SNEXT);
    endfunction

endpackage

// File: rtl/atbl_store.sv
module atbl_store import atbl_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [AW-1:0] raddr,
    output entry_t        rdata
);

    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        entry_t slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we && (waddr == AW'(g))) begin
                slot_q <= wdata;
            end
        end
        assign slots[g] = slot_q;
    end

    assign rdata = ({1'b0, raddr} < DEPTH_V) ? slots[raddr] : '0;

    // R7
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < DEPTH_V));

endmodule

// File: rtl/atbl_match.sv
module atbl_match import atbl_pkg::*; (
    input  entry_t           ent,
    input  logic [MAC_W-1:0] key_mac,
    input  logic [VID_W-1:0] key_vid,
    output logic             ent_valid,
    output logic             ent_match
);

    assign ent_valid = (ent.st != ENT_EMPTY);
    assign ent_match = ent_valid && (ent.mac == key_mac) && (ent.vid == key_vid);

endmodule

// File: rtl/atbl_ctrl.sv
module atbl_ctrl import atbl_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [OP_W-1:0]  op_i,
    input  entry_t           req_i,
    input  entry_t           rd_ent_i,
    input  logic             ent_valid_i,
    input  logic             ent_match_i,
    output logic [AW-1:0]    raddr_o,
    output logic             we_o,
    output logic [AW-1:0]    waddr_o,
    output entry_t           wdata_o,
    output logic [MAC_W-1:0] key_mac_o,
    output logic [VID_W-1:0] key_vid_o,
    output logic             busy_o,
    output logic             end_o,
    output logic             hit_o,
    output logic             inv_o,
    output logic [OP_W-1:0]  op_o,
    output entry_t           res_o
);

    localparam logic [IW-1:0] LAST  = IW'(DEPTH - 1);
    localparam logic [IW-1:0] PAST  = IW'(DEPTH);

    typedef enum logic [2:0] {
        S_IDLE, S_SCAN, S_COMMIT, S_FLUSH, S_SRCH
    } fsm_e;

    typedef struct packed {
        fsm_e            st;
        logic [OP_W-1:0] op;
        entry_t          req;
        logic [IW-1:0]   idx;
        logic            fnd;
        logic [AW-1:0]   fidx;
        logic            fre;
        logic [AW-1:0]   ridx;
        logic [IW-1:0]   nxt;
        logic            busy;
        logic            send;
        logic            hit;
        logic            inv;
        entry_t          res;
    } ctl_t;

    ctl_t d, q;

    assign raddr_o = (q.st == S_COMMIT) ? q.fidx : q.idx[AW-1:0];

    always_comb begin
        d       = q;
        we_o    = 1'b0;
        waddr_o = q.idx[AW-1:0];
        wdata_o = '0;
        case (q.st)
            S_IDLE: begin
                if (issue_i) begin
                    d.op   = op_i;
                    d.req  = req_i;
                    d.hit  = 1'b0;
                    d.send = 1'b0;
                    d.inv  = 1'b0;
                    d.fnd  = 1'b0;
                    d.fre  = 1'b0;
                    d.idx  = '0;
                    case (op_i)
                        OP_LOOKUP, OP_STORE: begin
                            d.busy = 1'b1;
                            d.st   = S_SCAN;
                        end
                        OP_FLUSH: begin
                            d.busy = 1'b1;
                            d.st   = S_FLUSH;
                        end
                        OP_SSTART: begin
                            d.busy = 1'b1;
                            d.st   = S_SRCH;
                        end
                        OP_SNEXT: begin
                            d.busy = 1'b1;
                            d.st   = S_SRCH;
                            d.idx  = q.nxt;
                        end
                        default: ;
                    endcase
                end
            end
            S_SCAN: begin
                if (ent_match_i && !q.fnd) begin
                    d.fnd  = 1'b1;
                    d.fidx = q.idx[AW-1:0];
                end
                if (!ent_valid_i && !q.fre) begin
                    d.fre  = 1'b1;
                    d.ridx = q.idx[AW-1:0];
                end
                if (q.idx == LAST) begin
                    d.st = S_COMMIT;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            S_COMMIT: begin
                if (q.op == OP_LOOKUP) begin
                    if (q.fnd) begin
                        d.res = rd_ent_i;
                    end else begin
                        d.inv = 1'b1;
                    end
                end else if (q.req.st == ENT_EMPTY) begin
                    if (q.fnd) begin
                        we_o    = 1'b1;
                        waddr_o = q.fidx;
                    end
                end else if (q.fnd) begin
                    we_o    = 1'b1;
                    waddr_o = q.fidx;
                    wdata_o = q.req;
                end else if (q.fre) begin
                    we_o    = 1'b1;
                    waddr_o = q.ridx;
                    wdata_o = q.req;
                end else begin
                    d.inv = 1'b1;
                end
                d.busy = 1'b0;
                d.st   = S_IDLE;
            end
            S_FLUSH: begin
                we_o = 1'b1;
                if (q.idx == LAST) begin
                    d.busy = 1'b0;
                    d.st   = S_IDLE;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            S_SRCH: begin
                if (q.idx >= PAST) begin
                    d.send = 1'b1;
                    d.nxt  = PAST;
                    d.busy = 1'b0;
                    d.st   = S_IDLE;
                end else if (ent_valid_i) begin
                    d.hit  = 1'b1;
                    d.res  = rd_ent_i;
                    d.send = (q.idx == LAST);
                    d.nxt  = q.idx + 1'b1;
                    d.busy = 1'b0;
                    d.st   = S_IDLE;
                end else if (q.idx == LAST) begin
                    d.send = 1'b1;
                    d.nxt  = PAST;
                    d.busy = 1'b0;
                    d.st   = S_IDLE;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign key_mac_o = q.req.mac;
    assign key_vid_o = q.req.vid;
    assign busy_o    = q.busy;
    assign end_o     = q.send;
    assign hit_o     = q.hit;
    assign inv_o     = q.inv;
    assign op_o      = q.op;
    assign res_o     = q.res;

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_known(op_i)) |=> busy_o);

    // R2
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(op_o));

    // R11
    odd_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !op_known(op_i)) |=> (!busy_o && !we_o));

    // R9
    hit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (res_o.st != ENT_EMPTY));

    // R4
    hit_inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && inv_o));

    // R10
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> !busy_o);

endmodule

// File: rtl/atbl_engine.sv
module atbl_engine import atbl_pkg::*; #(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        cmd_start,
    input  logic [2:0]  cmd_op,
    input  logic [31:0] wr_word0,
    input  logic [31:0] wr_word1,
    input  logic [31:0] wr_word2,
    output logic [15:0] cmd_status,
    output logic [31:0] rd_word0,
    output logic [31:0] rd_word1,
    output logic [31:0] rd_word2
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             issue;
    logic [AW-1:0]    raddr;
    logic [AW-1:0]    waddr;
    logic             we;
    entry_t           wdata;
    entry_t           rd_ent;
    entry_t           req;
    entry_t           res;
    logic             ent_valid;
    logic             ent_match;
    logic [MAC_W-1:0] key_mac;
    logic [VID_W-1:0] key_vid;
    logic             busy;
    logic             send;
    logic             hit;
    logic             inv;
    logic [OP_W-1:0]  op_q;

    assign issue = cmd_wr && cmd_start && !busy;
    assign req   = words_to_entry(wr_word0, wr_word1, wr_word2);

    atbl_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rd_ent)
    );

    atbl_match u_match (
        .ent       (rd_ent),
        .key_mac   (key_mac),
        .key_vid   (key_vid),
        .ent_valid (ent_valid),
        .ent_match (ent_match)
    );

    atbl_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue),
        .op_i        (cmd_op),
        .req_i       (req),
        .rd_ent_i    (rd_ent),
        .ent_valid_i (ent_valid),
        .ent_match_i (ent_match),
        .raddr_o     (raddr),
        .we_o        (we),
        .waddr_o     (waddr),
        .wdata_o     (wdata),
        .key_mac_o   (key_mac),
        .key_vid_o   (key_vid),
        .busy_o      (busy),
        .end_o       (send),
        .hit_o       (hit),
        .inv_o       (inv),
        .op_o        (op_q),
        .res_o       (res)
    );

    assign cmd_status = {busy, send, hit, inv, 9'h000, op_q};
    assign rd_word0   = entry_word0(res);
    assign rd_word1   = entry_word1(res);
    assign rd_word2   = entry_word2(res);

endmodule

// File: tb/tb_atbl_engine.sv
module tb_atbl_engine;

    localparam int DEPTH = 8;
    localparam int TMO   = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic        cmd_start = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] ww0 = '0, ww1 = '0, ww2 = '0;
    logic [15:0] st;
    logic [31:0] rw0, rw1, rw2;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    atbl_engine #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_start(cmd_start),
        .cmd_op(cmd_op), .wr_word0(ww0), .wr_word1(ww1), .wr_word2(ww2),
        .cmd_status(st), .rd_word0(rw0), .rd_word1(rw1), .rd_word2(rw2)
    );

    function automatic logic [31:0] kw0(int k);
        return 32'hA0B0_C000 + k;
    endfunction
    function automatic logic [31:0] kw1(int k, logic [11:0] vid);
        return {16'h5500 + 16'(k), 4'h0, vid};
    endfunction
    function automatic logic [31:0] ew2(logic [7:0] age, logic [7:0] pm, logic [1:0] s);
        return {age, 12'h000, pm, 2'b00, s};
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] op, logic go, logic [31:0] a, logic [31:0] b,
                         logic [31:0] c);
        cmd_wr = 1'b1; cmd_start = go; cmd_op = op; ww0 = a; ww1 = b; ww2 = c;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_start = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (st[15]) begin
            cyc++;
            if (cyc > TMO) begin
                n_fail++;
                $display("FAIL R2 busy stuck: actual %0d expected <= %0d", cyc, TMO);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                       output int cyc);
        issue(op, 1'b1, a, b, c);
        wait_idle(cyc);
    endtask

    task automatic rd_ok(string rq, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        int cyc;
        run(3'd0, a, b, 32'h0, cyc);
        chk(rq, "lookup invalid flag", 32'(st[12]), 0);
        chk(rq, "word0", rw0, a);
        chk(rq, "word1", rw1, b);
        chk(rq, "word2", rw2, c);
    endtask

    task automatic rd_miss(string rq, logic [31:0] a, logic [31:0] b);
        int cyc;
        run(3'd0, a, b, 32'h0, cyc);
        chk(rq, "lookup miss invalid flag", 32'(st[12]), 1);
    endtask

    task automatic srch(string rq, logic [2:0] op, logic h, logic e, logic [31:0] a,
                        logic [31:0] b, logic [31:0] c);
        int cyc;
        run(op, 32'h0, 32'h0, 32'h0, cyc);
        chk(rq, "hit flag", 32'(st[13]), 32'(h));
        chk(rq, "end flag", 32'(st[14]), 32'(e));
        if (h) begin
            chk(rq, "search word0", rw0, a);
            chk(rq, "search word1", rw1, b);
            chk(rq, "search word2", rw2, c);
        end
    endtask

    task automatic t_reset;
        chk("R1", "status after reset", 32'(st), 0);
        chk("R1", "rd word0 after reset", rw0, 0);
        chk("R1", "rd word2 after reset", rw2, 0);
        srch("R1", 3'd4, 1'b0, 1'b1, 0, 0, 0);
    endtask

    task automatic t_flush_busy;
        int cyc;
        run(3'd2, 0, 0, 0, cyc);
        chk("R8", "flush busy cycles >= DEPTH", 32'(cyc >= DEPTH), 1);
        chk("R2", "code field after flush", 32'(st[2:0]), 2);
    endtask

    task automatic t_store_lookup;
        int cyc;
        run(3'd1, 32'h1122_3344, 32'h5566_0005, ew2(8'h3C, 8'h05, 2'd3), cyc);
        chk("R2", "store accepted busy seen", 32'(cyc > 0), 1);
        rd_ok("R3", 32'h1122_3344, 32'h5566_0005, ew2(8'h3C, 8'h05, 2'd3));
        chk("R2", "code field after lookup", 32'(st[2:0]), 0);
    endtask

    task automatic t_miss;
        rd_miss("R4", 32'h1122_3344, 32'h5566_0009);
        rd_ok("R4", 32'h1122_3344, 32'h5566_0005, ew2(8'h3C, 8'h05, 2'd3));
    endtask

    task automatic t_overwrite;
        int cyc;
        run(3'd1, 32'h1122_3344, 32'h5566_0005, ew2(8'h01, 8'h42, 2'd1), cyc);
        rd_ok("R5", 32'h1122_3344, 32'h5566_0005, ew2(8'h01, 8'h42, 2'd1));
        run(3'd1, 32'h1122_3344, 32'h5566_0006, ew2(8'h02, 8'h11, 2'd3), cyc);
        rd_ok("R5", 32'h1122_3344, 32'h5566_0005, ew2(8'h01, 8'h42, 2'd1));
        rd_ok("R5", 32'h1122_3344, 32'h5566_0006, ew2(8'h02, 8'h11, 2'd3));
        srch("R5", 3'd4, 1'b1, 1'b0, 32'h1122_3344, 32'h5566_0005, ew2(8'h01, 8'h42, 2'd1));
        srch("R5", 3'd5, 1'b1, 1'b0, 32'h1122_3344, 32'h5566_0006, ew2(8'h02, 8'h11, 2'd3));
        srch("R5", 3'd5, 1'b0, 1'b1, 0, 0, 0);
    endtask

    task automatic t_erase;
        int cyc;
        run(3'd1, 32'h1122_3344, 32'h5566_0005, ew2(8'h00, 8'h00, 2'd0), cyc);
        rd_miss("R6", 32'h1122_3344, 32'h5566_0005);
        rd_ok("R6", 32'h1122_3344, 32'h5566_0006, ew2(8'h02, 8'h11, 2'd3));
    endtask

    task automatic t_order;
        int cyc;
        run(3'd2, 0, 0, 0, cyc);
        for (int k = 0; k < 3; k++) run(3'd1, kw0(k), kw1(k, 12'd7), ew2(8'(k), 8'h01, 2'd1), cyc);
        run(3'd1, kw0(1), kw1(1, 12'd7), 32'h0, cyc);
        run(3'd1, kw0(9), kw1(9, 12'd7), ew2(8'h99, 8'h80, 2'd3), cyc);
        srch("R9", 3'd4, 1'b1, 1'b0, kw0(0), kw1(0, 12'd7), ew2(8'd0, 8'h01, 2'd1));
        srch("R7", 3'd5, 1'b1, 1'b0, kw0(9), kw1(9, 12'd7), ew2(8'h99, 8'h80, 2'd3));
        srch("R9", 3'd5, 1'b1, 1'b0, kw0(2), kw1(2, 12'd7), ew2(8'd2, 8'h01, 2'd1));
        srch("R10", 3'd5, 1'b0, 1'b1, 0, 0, 0);
        srch("R10", 3'd5, 1'b0, 1'b1, 0, 0, 0);
    endtask

    task automatic t_full;
        int cyc;
        run(3'd2, 0, 0, 0, cyc);
        for (int k = 0; k < DEPTH; k++) run(3'd1, kw0(k), kw1(k, 12'd3), ew2(8'h10, 8'(k), 2'd3), cyc);
        run(3'd1, kw0(40), kw1(40, 12'd3), ew2(8'h10, 8'h01, 2'd1), cyc);
        chk("R7", "store into full table invalid", 32'(st[12]), 1);
        rd_miss("R7", kw0(40), kw1(40, 12'd3));
        srch("R9", 3'd4, 1'b1, 1'b0, kw0(0), kw1(0, 12'd3), ew2(8'h10, 8'd0, 2'd3));
        for (int k = 1; k < DEPTH - 1; k++)
            srch("R9", 3'd5, 1'b1, 1'b0, kw0(k), kw1(k, 12'd3), ew2(8'h10, 8'(k), 2'd3));
        srch("R10", 3'd5, 1'b1, 1'b1, kw0(DEPTH-1), kw1(DEPTH-1, 12'd3),
             ew2(8'h10, 8'(DEPTH-1), 2'd3));
        run(3'd2, 0, 0, 0, cyc);
        rd_miss("R8", kw0(0), kw1(0, 12'd3));
        srch("R8", 3'd4, 1'b0, 1'b1, 0, 0, 0);
    endtask

    task automatic t_ignore;
        int cyc;
        issue(3'd1, 1'b0, kw0(50), kw1(50, 12'd1), ew2(8'h1, 8'h1, 2'd1));
        chk("R2", "start bit clear gives no busy", 32'(st[15]), 0);
        rd_miss("R2", kw0(50), kw1(50, 12'd1));
        issue(3'd2, 1'b1, 0, 0, 0);
        chk("R2", "busy after flush issue", 32'(st[15]), 1);
        issue(3'd1, 1'b1, kw0(51), kw1(51, 12'd1), ew2(8'h1, 8'h1, 2'd1));
        chk("R2", "code held while busy", 32'(st[2:0]), 2);
        wait_idle(cyc);
        rd_miss("R2", kw0(51), kw1(51, 12'd1));
    endtask

    task automatic t_odd_codes;
        int cyc;
        run(3'd1, kw0(60), kw1(60, 12'd2), ew2(8'h5, 8'h3, 2'd1), cyc);
        run(3'd3, kw0(61), kw1(61, 12'd2), ew2(8'h5, 8'h3, 2'd1), cyc);
        chk("R11", "code 3 busy cycles", 32'(cyc), 0);
        run(3'd6, 0, 0, 0, cyc);
        chk("R11", "code 6 busy cycles", 32'(cyc), 0);
        run(3'd7, 0, 0, 0, cyc);
        chk("R11", "code 7 busy cycles", 32'(cyc), 0);
        rd_ok("R11", kw0(60), kw1(60, 12'd2), ew2(8'h5, 8'h3, 2'd1));
        rd_miss("R11", kw0(61), kw1(61, 12'd2));
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flush_busy();
        t_store_lookup();
        t_miss();
        t_overwrite();
        t_erase();
        t_order();
        t_full();
        t_ignore();
        t_odd_codes();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

endmodule